// File: doc/BRIEF.md
# Ordered Store Buffer with Fence and Atomic Drain

This block sits between a core's retire stage and its data cache. Retired stores are accepted into a small circular queue and written to the cache later, one per accepted handshake, always starting from the oldest. The core can keep running while its stores wait. Other agents can only see a store once it has been written to the cache.

Loads look up the queue in the same cycle. A load whose requested bytes are all covered by the youngest buffered store that shares any of those bytes takes its data from that store. A load that shares no bytes with any buffered store misses and goes to the cache at once, ahead of older buffered stores to other locations. This is the only reordering the block allows: a later load may pass an earlier store.

A load that shares only some of its bytes with that youngest store reports a stall instead. Fence and atomic read-modify-write requests hold off new stores. Their done outputs rise once the queue has fully drained.

Top module: `tso_store_queue`

## Requirements
- R1: Stores are offered on the cache write port strictly in the order they were accepted, and each one only after every older one has completed a handshake there.
- R2: While the cache write port is offering a store and `wr_ready` is low, `wr_valid`, `wr_addr`, `wr_data` and `wr_be` hold their values.
- R3: When `ld_valid` is high, the queue is searched for the youngest entry with the same word address that shares at least one byte-enable bit with `ld_be` (bit i of a byte enable selects data bits 8i+7..8i). If that entry's enables cover every bit of `ld_be`, then `ld_hit` is 1 and `ld_data` returns that entry's full data word.
- R4: A load that shares no enabled byte with any buffered entry gives `ld_hit` = 0, `ld_stall` = 0 and `ld_data` = 0, whatever older stores to other bytes or addresses are still buffered.
- R5: If the youngest entry found under R3 does not cover every bit of `ld_be`, then `ld_stall` is 1 and `ld_hit` is 0.
- R6: When the queue holds DEPTH entries, `st_ready` is low and a store presented on the enqueue port is not taken.
- R7: While `fence_req` is high, `st_ready` is low. `fence_done` is high exactly in the cycles in which `fence_req` is high, the queue is empty and no write is being offered.
- R8: While `amo_req` is high, `st_ready` is low. `amo_done` is high exactly in the cycles in which `amo_req` is high and the queue is empty.
- R9: After reset the queue is empty: `wr_valid` is 0, `st_ready` is 1 and every load misses.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| st_valid | input | 1 | Store enqueue request |
| st_ready | output | 1 | Store can be accepted |
| st_addr | input | AW | Store word address |
| st_data | input | DW | Store data |
| st_be | input | DW/8 | Store byte enables |
| ld_valid | input | 1 | Load lookup request |
| ld_addr | input | AW | Load word address |
| ld_be | input | DW/8 | Load byte enables |
| ld_hit | output | 1 | Load fully forwarded from the queue |
| ld_stall | output | 1 | Load partly overlaps a buffered store |
| ld_data | output | DW | Forwarded data |
| wr_valid | output | 1 | Cache write offered |
| wr_ready | input | 1 | Cache accepts the write |
| wr_addr | output | AW | Cache write word address |
| wr_data | output | DW | Cache write data |
| wr_be | output | DW/8 | Cache write byte enables |
| fence_req | input | 1 | Full fence request |
| fence_done | output | 1 | Fence complete |
| amo_req | input | 1 | Atomic read-modify-write request |
| amo_done | output | 1 | Queue drained, atomic may proceed |

## Verification
The bench builds the block with DEPTH 4, AW 8 and DW 32. With a four-entry queue, the full condition and the refusal of a fifth store are reached after only a few stores, and every slot is used before the pointers wrap. It holds `wr_ready` low so that the queue contains two stores to one word with different byte enables. This makes the youngest-entry choice, forwarding from an older entry behind a narrower younger one, and the partial-overlap stall all visible at the ports.

// File: rtl/tso_store_queue.sv
module tso_store_queue #(
  parameter int AW    = 16,
  parameter int DW    = 32,
  parameter int DEPTH = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            st_valid,
  output logic            st_ready,
  input  logic [AW-1:0]   st_addr,
  input  logic [DW-1:0]   st_data,
  input  logic [DW/8-1:0] st_be,
  input  logic            ld_valid,
  input  logic [AW-1:0]   ld_addr,
  input  logic [DW/8-1:0] ld_be,
  output logic            ld_hit,
  output logic            ld_stall,
  output logic [DW-1:0]   ld_data,
  output logic            wr_valid,
  input  logic            wr_ready,
  output logic [AW-1:0]   wr_addr,
  output logic [DW-1:0]   wr_data,
  output logic [DW/8-1:0] wr_be,
  input  logic            fence_req,
  output logic            fence_done,
  input  logic            amo_req,
  output logic            amo_done
);
  localparam int BW = DW / 8;
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [AW-1:0] q_addr [DEPTH];
  logic [DW-1:0] q_data [DEPTH];
  logic [BW-1:0] q_be   [DEPTH];
  logic [PW-1:0] head, tail;
  logic [PW:0]   cnt;

  wire empty = (cnt == '0);
  wire full  = (cnt == (PW+1)'(DEPTH));
  wire push  = st_valid && st_ready;
  wire pop   = wr_valid && wr_ready;

  assign st_ready   = !full && !fence_req && !amo_req;
  assign wr_valid   = !empty;
  assign wr_addr    = q_addr[head];
  assign wr_data    = q_data[head];
  assign wr_be      = q_be[head];
  assign fence_done = fence_req && empty && !wr_valid;
  assign amo_done   = amo_req && empty;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      head <= '0;
      tail <= '0;
      cnt  <= '0;
    end else begin
      if (push) begin
        q_addr[tail] <= st_addr;
        q_data[tail] <= st_data;
        q_be[tail]   <= st_be;
        tail         <= (tail == PW'(DEPTH-1)) ? '0 : tail + 1'b1;
      end
      if (pop)
        head <= (head == PW'(DEPTH-1)) ? '0 : head + 1'b1;
      if (push && !pop)
        cnt <= cnt + 1'b1;
      else if (pop && !push)
        cnt <= cnt - 1'b1;
    end
  end

  logic          found;
  logic [BW-1:0] sel_be;
  logic [DW-1:0] sel_data;

  always_comb begin
    found    = 1'b0;
    sel_be   = '0;
    sel_data = '0;
    for (int k = 0; k < DEPTH; k++) begin
      logic [PW:0] wide;
      logic [PW-1:0] idx;
      wide = (PW+1)'(head) + (PW+1)'(k);
      idx  = (wide >= (PW+1)'(DEPTH)) ? PW'(wide - (PW+1)'(DEPTH)) : PW'(wide);
      if ((PW+1)'(k) < cnt && q_addr[idx] == ld_addr && |(q_be[idx] & ld_be)) begin
        found    = 1'b1;
        sel_be   = q_be[idx];
        sel_data = q_data[idx];
      end
    end
  end

  wire covered = ((ld_be & ~sel_be) == '0);

  assign ld_hit   = ld_valid && found && covered;
  assign ld_stall = ld_valid && found && !covered;
  assign ld_data  = ld_hit ? sel_data : '0;

endmodule

// File: rtl/tso_store_queue_chk.sv
module tso_store_queue_chk #(
  parameter int AW    = 16,
  parameter int DW    = 32,
  parameter int DEPTH = 8
) (
  input logic                          clk,
  input logic                          rst_n,
  input logic                          st_valid,
  input logic                          st_ready,
  input logic                          ld_hit,
  input logic                          ld_stall,
  input logic                          wr_valid,
  input logic                          wr_ready,
  input logic [AW-1:0]                 wr_addr,
  input logic [DW-1:0]                 wr_data,
  input logic [DW/8-1:0]               wr_be,
  input logic                          fence_done,
  input logic                          amo_req,
  input logic [((DEPTH>1)?$clog2(DEPTH):1):0] cnt
);
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  AST_DRAIN_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && wr_ready && !(st_valid && st_ready)) |=> (cnt == $past(cnt) - 1'b1)); // R1

  AST_WRITE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && !wr_ready) |=> (wr_valid && $stable(wr_addr) && $stable(wr_data) && $stable(wr_be))); // R2

  AST_HIT_STALL_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(ld_hit && ld_stall)); // R5

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt == (PW+1)'(DEPTH)) |-> !st_ready); // R6

  AST_FENCE_DRAINED: assert property (@(posedge clk) disable iff (!rst_n)
    fence_done |-> (cnt == '0 && !wr_valid)); // R7

  AST_AMO_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
    amo_req |-> !st_ready); // R8
endmodule

bind tso_store_queue tso_store_queue_chk #(.AW(AW), .DW(DW), .DEPTH(DEPTH)) u_chk (.*);

// File: tb/sim_tso_store_queue.sv
`timescale 1ns/100ps
module sim_tso_store_queue;
  localparam int AW = 8, DW = 32, DEPTH = 4, BW = DW/8;

  logic clk = 0, rst_n = 0;
  logic st_valid = 0, ld_valid = 0, wr_ready = 0, fence_req = 0, amo_req = 0;
  logic [AW-1:0] st_addr = '0, ld_addr = '0;
  logic [DW-1:0] st_data = '0;
  logic [BW-1:0] st_be = '0, ld_be = '0;
  logic st_ready, ld_hit, ld_stall, wr_valid, fence_done, amo_done;
  logic [DW-1:0] ld_data, wr_data;
  logic [AW-1:0] wr_addr;
  logic [BW-1:0] wr_be;

  int checks = 0, fails = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  tso_store_queue #(.AW(AW), .DW(DW), .DEPTH(DEPTH)) u0 (.*);

  // {addr, be, hit, stall, data}
  localparam logic [45:0] LT [8] = '{
    {8'h10, 4'h1, 2'b10, 32'h33333333},
    {8'h10, 4'hF, 2'b01, 32'h00000000},
    {8'h10, 4'h2, 2'b10, 32'h11111111},
    {8'h20, 4'h1, 2'b10, 32'h22222222},
    {8'h20, 4'h4, 2'b00, 32'h00000000},
    {8'h20, 4'h6, 2'b01, 32'h00000000},
    {8'h40, 4'hF, 2'b00, 32'h00000000},
    {8'h30, 4'hF, 2'b10, 32'h44444444}
  };

  task automatic chk(bit ok, string req, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic push(logic [AW-1:0] a, logic [DW-1:0] d, logic [BW-1:0] b);
    st_valid = 1; st_addr = a; st_data = d; st_be = b;
    @(negedge clk);
    st_valid = 0;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  endtask

  initial begin
    #(200000 * 5);
    checks++; fails++;
    $display("FAIL watchdog actual=timeout expected=completion");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    // R9 reset state
    ld_valid = 1; ld_addr = 8'h10; ld_be = 4'hF; #1;
    chk(wr_valid == 0, "R9 wr_valid", wr_valid, 0);
    chk(st_ready == 1, "R9 st_ready", st_ready, 1);
    chk(ld_hit == 0 && ld_stall == 0, "R9 load miss", {ld_hit, ld_stall}, 0);
    ld_valid = 0;
    rst_n = 1;
    @(negedge clk);

    push(8'h10, 32'h11111111, 4'hF);
    push(8'h20, 32'h22222222, 4'h3);
    push(8'h10, 32'h33333333, 4'h1);
    push(8'h30, 32'h44444444, 4'hF);

    // R6 full: fifth store refused
    st_valid = 1; st_addr = 8'h50; st_data = 32'h55555555; st_be = 4'hF; #1;
    chk(st_ready == 0, "R6 full st_ready", st_ready, 0);
    @(negedge clk);
    st_valid = 0;

    // R3 R4 R5 lookup table
    foreach (LT[i]) begin
      ld_valid = 1; ld_addr = LT[i][45:38]; ld_be = LT[i][37:34]; #1;
      chk(ld_hit == LT[i][33], "R3 R4 ld_hit", ld_hit, LT[i][33]);
      chk(ld_stall == LT[i][32], "R5 ld_stall", ld_stall, LT[i][32]);
      chk(ld_data == LT[i][31:0], "R3 R4 ld_data", ld_data, LT[i][31:0]);
      @(negedge clk);
    end
    ld_valid = 0;

    // R2 hold while not ready
    chk(wr_valid && wr_addr == 8'h10 && wr_data == 32'h11111111, "R2 head held",
        {wr_valid, wr_addr, wr_data}, {1'b1, 8'h10, 32'h11111111});

    // R1 drain order, R6 refused store absent
    wr_ready = 1;
    chk(wr_addr == 8'h10 && wr_data == 32'h11111111 && wr_be == 4'hF, "R1 order 0", wr_data, 32'h11111111);
    @(negedge clk);
    chk(wr_addr == 8'h20 && wr_data == 32'h22222222 && wr_be == 4'h3, "R1 order 1", wr_data, 32'h22222222);
    @(negedge clk);
    chk(wr_addr == 8'h10 && wr_data == 32'h33333333 && wr_be == 4'h1, "R1 order 2", wr_data, 32'h33333333);
    @(negedge clk);
    chk(wr_addr == 8'h30 && wr_data == 32'h44444444 && wr_be == 4'hF, "R1 order 3", wr_data, 32'h44444444);
    @(negedge clk);
    chk(wr_valid == 0, "R6 refused store not queued", wr_valid, 0);
    wr_ready = 0;

    // R7 fence
    push(8'h60, 32'h66666666, 4'hF);
    push(8'h61, 32'h77777777, 4'hF);
    fence_req = 1; st_valid = 1; st_addr = 8'h62; st_data = 32'h88888888; st_be = 4'hF; #1;
    chk(fence_done == 0, "R7 fence pending", fence_done, 0);
    chk(st_ready == 0, "R7 stores held", st_ready, 0);
    @(negedge clk);
    st_valid = 0; wr_ready = 1; #1;
    chk(fence_done == 0, "R7 fence two left", fence_done, 0);
    @(negedge clk);
    chk(fence_done == 0 && wr_addr == 8'h61, "R7 fence one left", {fence_done, wr_addr}, {1'b0, 8'h61});
    @(negedge clk);
    chk(fence_done == 1 && wr_valid == 0, "R7 fence done on empty", {fence_done, wr_valid}, 2'b10);
    fence_req = 0; wr_ready = 0; #1;
    chk(fence_done == 0, "R7 done follows req", fence_done, 0);

    // R8 atomic
    @(negedge clk);
    push(8'h70, 32'h99999999, 4'hF);
    amo_req = 1; #1;
    chk(amo_done == 0 && st_ready == 0, "R8 amo waits", {amo_done, st_ready}, 0);
    wr_ready = 1;
    @(negedge clk);
    chk(amo_done == 1, "R8 amo done", amo_done, 1);
    chk(st_ready == 0, "R8 later stores held", st_ready, 0);
    amo_req = 0; wr_ready = 0; #1;
    chk(st_ready == 1 && amo_done == 0, "R8 release", {st_ready, amo_done}, 2'b10);

    finish_run();
  end
endmodule